// File: doc/BRIEF.md
# External Interrupt Controller with Per-Line Sense Selection

This block collects up to 32 external interrupt pins and turns them into one interrupt request toward a processor, plus a separate non-maskable request. Each pin first passes through a two-flop synchronizer. Each line then has its own sense condition: low level, high level, rising edge or falling edge. A detected condition raises the line's pending flag. Software reads these flags over a simple 32-bit register bus, clears them and masks them.

Masking uses two registers. Writing to one sets mask bits and writing to the other clears them, so software never needs a read-modify-write. The number of implemented lines is a build parameter. Software finds it by writing all ones to the sense-mode register and reading it back. The combined request is raised whenever a pending line is also unmasked. Software does the priority resolution by scanning the pending and mask registers.

Top module: `ext_irq_ctrl`

## Requirements
- R1: After reset, the mask, pending, mode, edge-polarity, level-polarity and non-maskable-enable registers all read 0, and both `irq_o` and `nmi_o` are low.
- R2: Writing to the mask-set register (offset 0x00) sets each mask bit whose data bit is 1. Writing to the mask-clear register (offset 0x04) clears each mask bit whose data bit is 1. Data bits of 0 leave the mask unchanged. The mask reads back at offset 0x08.
- R3: A line whose mode bit (offset 0x14) is 0 uses edge sensing. If its edge-polarity bit (offset 0x18) is 1, a rising pin transition sets its pending bit. If that bit is 0, a falling transition sets it. A transition of the other direction has no effect. The pending bit is visible at offset 0x0C within four clock cycles of the pin change.
- R4: In edge mode, a pending bit stays set until software writes 1 to that bit of the pending-clear register (offset 0x10).
- R5: A line whose mode bit is 1 uses level sensing. The level-polarity bit (offset 0x1C) selects active-high when 1 and active-low when 0. The pending bit follows the synchronized pin continuously, so a clear write does not remove it while the level is still active.
- R6: If a pending-clear write and a new edge detection on the same line fall in the same cycle, the pending bit ends up set.
- R7: Only the lowest NUM_LINES bits of each line register exist. The other bits read 0 and ignore writes. After all ones are written to the mode register, it reads back with exactly NUM_LINES low bits set.
- R8: `irq_o` is high exactly when at least one line is both pending and unmasked.
- R9: Bit 0 of the non-maskable control register (offset 0x24) enables the non-maskable path. `nmi_o` is high exactly when that bit is 1 and line 0 is pending, regardless of line 0's mask bit.
- R10: The write-only registers (0x00, 0x04, 0x10) and any unassigned offset read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| bus_addr | input | ADDR_W | Byte offset of the register being accessed |
| bus_we | input | 1 | Write strobe, one write per cycle it is high |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| ext_pin | input | NUM_LINES | Asynchronous external interrupt pins |
| irq_o | output | 1 | Combined maskable interrupt request |
| nmi_o | output | 1 | Non-maskable interrupt request from line 0 |

## Verification
The bench places a pending-clear write in exactly the cycle in which a synchronized rising edge is detected. A design that gives the clear priority would lose that interrupt, and the line would read 0 instead of 1. It checks that a transition of the non-selected direction leaves the pending bit alone, and that a clear write has no lasting effect on an active level line. A design that latched level events, or confused the polarity bits, would show a stale or missing pending bit. It also checks three boundary cases: the read-back of an all-ones mode write, the zero read-back of write-only registers, and a non-maskable request raised while line 0 is masked. A wrong implemented-line width or a mask-gated non-maskable path would be visible there.

// File: rtl/ext_irq_pkg.sv
package ext_irq_pkg;

  localparam int BUS_W         = 32;
  localparam int LINES_MAX     = 32;

  // byte offsets of the register map
  localparam int REG_EN_SET    = 'h00;
  localparam int REG_EN_CLR    = 'h04;
  localparam int REG_MASK      = 'h08;
  localparam int REG_STAT      = 'h0C;
  localparam int REG_STAT_CLR  = 'h10;
  localparam int REG_MODE      = 'h14;
  localparam int REG_EDGE      = 'h18;
  localparam int REG_LEVEL     = 'h1C;
  localparam int REG_NMI       = 'h24;

  typedef enum logic [1:0] {
    SENSE_FALL = 2'b00,
    SENSE_RISE = 2'b01,
    SENSE_LOW  = 2'b10,
    SENSE_HIGH = 2'b11
  } sense_e;

  // bit vector with the lowest n positions set
  function automatic logic [BUS_W-1:0] impl_mask(int n);
    logic [BUS_W-1:0] m;
    for (int i = 0; i < BUS_W; i++) begin
      m[i] = (i < n);
    end
    return m;
  endfunction

  function automatic sense_e sense_of(logic mode, logic edge_pol, logic level_pol);
    if (mode) begin
      return level_pol ? SENSE_HIGH : SENSE_LOW;
    end
    return edge_pol ? SENSE_RISE : SENSE_FALL;
  endfunction

endpackage

// File: rtl/eic_pin_sync.sv
module eic_pin_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    logic [W-1:0] stage_d;
    if (s == 0) begin : g_first
      assign stage_d = d;
    end else begin : g_next
      assign stage_d = stage_q[s-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        stage_q[s] <= '0;
      end else begin
        stage_q[s] <= stage_d;
      end
    end
  end

  assign q = stage_q[STAGES-1];

endmodule

// File: rtl/eic_sense_line.sv
module eic_sense_line
  import ext_irq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic pin_s,
  input  logic cfg_mode,
  input  logic cfg_edge,
  input  logic cfg_level,
  input  logic clr,
  output logic status_o
);

  logic   prev_q;
  logic   status_q;
  logic   status_d;
  logic   status_en;
  logic   rise;
  logic   fall;
  logic   hit;
  sense_e sense;

  always_comb begin
    sense = sense_of(cfg_mode, cfg_edge, cfg_level);
    rise  = pin_s & ~prev_q;
    fall  = ~pin_s & prev_q;
    unique case (sense)
      SENSE_FALL: hit = fall;
      SENSE_RISE: hit = rise;
      SENSE_LOW:  hit = ~pin_s;
      SENSE_HIGH: hit = pin_s;
      default:    hit = 1'b0;
    endcase
    if (cfg_mode) begin
      // level: flag tracks the active level
      status_d = hit;
    end else begin
      // edge: sticky, a fresh hit beats a clear
      status_d = hit | (status_q & ~clr);
    end
    status_en = (status_d != status_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
    end else begin
      prev_q <= pin_s;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_q <= 1'b0;
    end else if (status_en) begin
      status_q <= status_d;
    end
  end

  assign status_o = status_q;

endmodule

// File: rtl/eic_regfile.sv
module eic_regfile
  import ext_irq_pkg::*;
#(
  parameter int NUM_LINES = 20,
  parameter int ADDR_W    = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [ADDR_W-1:0]    addr,
  input  logic                 we,
  input  logic [BUS_W-1:0]     wdata,
  input  logic [NUM_LINES-1:0] status_i,
  output logic [NUM_LINES-1:0] mask_o,
  output logic [NUM_LINES-1:0] mode_o,
  output logic [NUM_LINES-1:0] edge_o,
  output logic [NUM_LINES-1:0] level_o,
  output logic                 nmi_en_o,
  output logic [NUM_LINES-1:0] stat_clr_o,
  output logic [BUS_W-1:0]     rdata_o
);

  localparam logic [BUS_W-1:0] IMPL32 = impl_mask(NUM_LINES);

  logic [NUM_LINES-1:0] mask_q,  mask_d;
  logic [NUM_LINES-1:0] mode_q,  mode_d;
  logic [NUM_LINES-1:0] edge_q,  edge_d;
  logic [NUM_LINES-1:0] level_q, level_d;
  logic                 nmi_q,   nmi_d;
  logic                 mask_en, mode_en, edge_en, level_en, nmi_en;
  logic [NUM_LINES-1:0] wr_bits;
  logic                 sel_set, sel_clr, sel_sclr, sel_mode, sel_edge, sel_level, sel_nmi;
  logic                 unused_wdata_hi;
  int                   offs;

  function automatic logic [BUS_W-1:0] widen(logic [NUM_LINES-1:0] v);
    logic [BUS_W-1:0] r;
    r = '0;
    r[NUM_LINES-1:0] = v;
    return r;
  endfunction

  assign offs    = int'(addr);
  assign wr_bits = wdata[NUM_LINES-1:0];
  assign unused_wdata_hi = ^(wdata & ~IMPL32);

  // write decode
  always_comb begin
    sel_set   = we && (offs == REG_EN_SET);
    sel_clr   = we && (offs == REG_EN_CLR);
    sel_sclr  = we && (offs == REG_STAT_CLR);
    sel_mode  = we && (offs == REG_MODE);
    sel_edge  = we && (offs == REG_EDGE);
    sel_level = we && (offs == REG_LEVEL);
    sel_nmi   = we && (offs == REG_NMI);
  end

  // next-state
  always_comb begin
    mask_d = mask_q;
    if (sel_set) begin
      mask_d = mask_d | wr_bits;
    end
    if (sel_clr) begin
      mask_d = mask_d & ~wr_bits;
    end
    mask_en    = sel_set | sel_clr;
    mode_d     = wr_bits;
    mode_en    = sel_mode;
    edge_d     = wr_bits;
    edge_en    = sel_edge;
    level_d    = wr_bits;
    level_en   = sel_level;
    nmi_d      = wdata[0];
    nmi_en     = sel_nmi;
    stat_clr_o = sel_sclr ? wr_bits : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
    end else if (mask_en) begin
      mask_q <= mask_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
    end else if (mode_en) begin
      mode_q <= mode_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      edge_q <= '0;
    end else if (edge_en) begin
      edge_q <= edge_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      level_q <= '0;
    end else if (level_en) begin
      level_q <= level_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nmi_q <= 1'b0;
    end else if (nmi_en) begin
      nmi_q <= nmi_d;
    end
  end

  // read mux
  always_comb begin
    unique case (offs)
      REG_MASK:  rdata_o = widen(mask_q);
      REG_STAT:  rdata_o = widen(status_i);
      REG_MODE:  rdata_o = widen(mode_q);
      REG_EDGE:  rdata_o = widen(edge_q);
      REG_LEVEL: rdata_o = widen(level_q);
      REG_NMI:   rdata_o = {{(BUS_W-1){1'b0}}, nmi_q};
      default:   rdata_o = '0;
    endcase
  end

  assign mask_o   = mask_q;
  assign mode_o   = mode_q;
  assign edge_o   = edge_q;
  assign level_o  = level_q;
  assign nmi_en_o = nmi_q;

endmodule

// File: rtl/ext_irq_ctrl.sv
module ext_irq_ctrl
  import ext_irq_pkg::*;
#(
  parameter int NUM_LINES   = 20,
  parameter int ADDR_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic                 bus_we,
  input  logic [BUS_W-1:0]     bus_wdata,
  output logic [BUS_W-1:0]     bus_rdata,
  input  logic [NUM_LINES-1:0] ext_pin,
  output logic                 irq_o,
  output logic                 nmi_o
);

  logic                 rst_core_n;
  logic [NUM_LINES-1:0] pin_s;
  logic [NUM_LINES-1:0] mask_q;
  logic [NUM_LINES-1:0] mode_q;
  logic [NUM_LINES-1:0] edge_q;
  logic [NUM_LINES-1:0] level_q;
  logic [NUM_LINES-1:0] stat_clr;
  logic [NUM_LINES-1:0] status_q;
  logic                 nmi_en_q;

  // reset: asserted asynchronously, released on the clock
  eic_pin_sync #(.W(1), .STAGES(2)) u_rst_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (1'b1),
    .q     (rst_core_n)
  );

  eic_pin_sync #(.W(NUM_LINES), .STAGES(SYNC_STAGES)) u_pin_sync (
    .clk   (clk),
    .rst_n (rst_core_n),
    .d     (ext_pin),
    .q     (pin_s)
  );

  eic_regfile #(.NUM_LINES(NUM_LINES), .ADDR_W(ADDR_W)) u_regs (
    .clk        (clk),
    .rst_n      (rst_core_n),
    .addr       (bus_addr),
    .we         (bus_we),
    .wdata      (bus_wdata),
    .status_i   (status_q),
    .mask_o     (mask_q),
    .mode_o     (mode_q),
    .edge_o     (edge_q),
    .level_o    (level_q),
    .nmi_en_o   (nmi_en_q),
    .stat_clr_o (stat_clr),
    .rdata_o    (bus_rdata)
  );

  for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
    eic_sense_line u_line (
      .clk       (clk),
      .rst_n     (rst_core_n),
      .pin_s     (pin_s[i]),
      .cfg_mode  (mode_q[i]),
      .cfg_edge  (edge_q[i]),
      .cfg_level (level_q[i]),
      .clr       (stat_clr[i]),
      .status_o  (status_q[i])
    );
  end

  assign irq_o = |(status_q & mask_q);
  assign nmi_o = nmi_en_q & status_q[0];

endmodule

// File: rtl/ext_irq_ctrl_chk.sv
module ext_irq_ctrl_chk
  import ext_irq_pkg::*;
#(
  parameter int NUM_LINES = 20,
  parameter int ADDR_W    = 8
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [ADDR_W-1:0]    bus_addr,
  input logic                 bus_we,
  input logic [BUS_W-1:0]     bus_wdata,
  input logic [BUS_W-1:0]     bus_rdata,
  input logic                 irq_o,
  input logic                 nmi_o,
  input logic [NUM_LINES-1:0] mask_q,
  input logic [NUM_LINES-1:0] mode_q,
  input logic [NUM_LINES-1:0] status_q
);

  localparam logic [BUS_W-1:0] IMPL32 = impl_mask(NUM_LINES);

  logic [NUM_LINES-1:0] wbits;
  logic [NUM_LINES-1:0] clr_vec;
  logic                 wr_set, wr_clr, wr_nmi_off;
  logic                 unused_hi;

  assign wbits      = bus_wdata[NUM_LINES-1:0];
  assign wr_set     = bus_we && (int'(bus_addr) == REG_EN_SET);
  assign wr_clr     = bus_we && (int'(bus_addr) == REG_EN_CLR);
  assign wr_nmi_off = bus_we && (int'(bus_addr) == REG_NMI) && !bus_wdata[0];
  assign clr_vec    = (bus_we && (int'(bus_addr) == REG_STAT_CLR)) ? wbits : '0;
  assign unused_hi  = ^(bus_wdata & ~IMPL32);

  AST_MASK_SET: assert property (@(posedge clk) disable iff (!rst_n)
    wr_set |=> ((mask_q & $past(wbits)) == $past(wbits)));  // R2

  AST_MASK_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    wr_clr |=> ((mask_q & $past(wbits)) == '0));  // R2

  AST_EDGE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(status_q & ~mode_q & ~clr_vec) & ~status_q) == '0));  // R4

  AST_UNIMPL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    ((bus_rdata & ~IMPL32) == '0));  // R7

  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q == '0) |-> !irq_o);  // R8

  AST_NMI_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    wr_nmi_off |=> !nmi_o);  // R9

  AST_NMI_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    nmi_o |-> status_q[0]);  // R9

endmodule

bind ext_irq_ctrl ext_irq_ctrl_chk #(.NUM_LINES(NUM_LINES), .ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_core_n),
  .bus_addr  (bus_addr),
  .bus_we    (bus_we),
  .bus_wdata (bus_wdata),
  .bus_rdata (bus_rdata),
  .irq_o     (irq_o),
  .nmi_o     (nmi_o),
  .mask_q    (mask_q),
  .mode_q    (mode_q),
  .status_q  (status_q)
);

// File: tb/ext_irq_ctrl_tb.sv
`timescale 1ns/1ps
module ext_irq_ctrl_tb;
  import ext_irq_pkg::*;

  localparam int NL = 20;
  localparam logic [31:0] IMPL = 32'h000F_FFFF;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [7:0]    bus_addr;
  logic          bus_we;
  logic [31:0]   bus_wdata;
  logic [31:0]   bus_rdata;
  logic [NL-1:0] ext_pin;
  logic          irq_o;
  logic          nmi_o;

  int checks   = 0;
  int failures = 0;
  bit done     = 0;

  typedef struct {
    int          kind;   // 0 read data, 1 irq_o, 2 nmi_o
    logic [31:0] exp;
    string       tag;
  } item_t;

  item_t sb_q[$];

  always #4 clk = ~clk;

  ext_irq_ctrl #(.NUM_LINES(NL), .ADDR_W(8)) u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_we    (bus_we),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .ext_pin   (ext_pin),
    .irq_o     (irq_o),
    .nmi_o     (nmi_o)
  );

  // monitor: compares results as the design presents them
  always @(negedge clk) begin
    if (sb_q.size() > 0) begin
      item_t it;
      logic [31:0] act;
      it = sb_q.pop_front();
      case (it.kind)
        0:       act = bus_rdata;
        1:       act = {31'd0, irq_o};
        default: act = {31'd0, nmi_o};
      endcase
      checks++;
      if (act !== it.exp) begin
        failures++;
        $display("FAIL %s actual=%h expected=%h", it.tag, act, it.exp);
      end
    end
  end

  task automatic print_summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  task automatic push(int kind, int a, logic [31:0] e, string tag);
    item_t it;
    @(posedge clk); #1;
    bus_addr = 8'(a);
    bus_we   = 1'b0;
    it.kind = kind; it.exp = e; it.tag = tag;
    sb_q.push_back(it);
    @(negedge clk); #1;
  endtask

  task automatic exp_reg(int a, logic [31:0] e, string tag);
    push(0, a, e, tag);
  endtask

  task automatic exp_irq(logic e, string tag);
    push(1, REG_MASK, {31'd0, e}, tag);
  endtask

  task automatic exp_nmi(logic e, string tag);
    push(2, REG_MASK, {31'd0, e}, tag);
  endtask

  task automatic wr(int a, logic [31:0] d);
    @(posedge clk); #1;
    bus_addr  = 8'(a);
    bus_we    = 1'b1;
    bus_wdata = d;
    @(posedge clk); #1;
    bus_we    = 1'b0;
  endtask

  task automatic set_pin(int idx, logic v);
    @(posedge clk); #1;
    ext_pin[idx] = v;
    repeat (5) @(posedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      print_summary();
      $finish;
    end
  end

  initial begin
    rst_n     = 1'b0;
    bus_addr  = '0;
    bus_we    = 1'b0;
    bus_wdata = '0;
    ext_pin   = '0;
    repeat (5) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (5) @(posedge clk);

    // R1 reset state
    exp_reg(REG_MASK,  32'h0, "R1 mask after reset");
    exp_reg(REG_STAT,  32'h0, "R1 pending after reset");
    exp_reg(REG_MODE,  32'h0, "R1 mode after reset");
    exp_reg(REG_EDGE,  32'h0, "R1 edge after reset");
    exp_reg(REG_LEVEL, 32'h0, "R1 level after reset");
    exp_reg(REG_NMI,   32'h0, "R1 nmi enable after reset");
    exp_irq(1'b0, "R1 irq after reset");
    exp_nmi(1'b0, "R1 nmi after reset");

    // R7 line discovery; all lines go level active-low for a moment
    wr(REG_MODE, 32'hFFFF_FFFF);
    exp_reg(REG_MODE, IMPL, "R7 mode all-ones readback");
    repeat (3) @(posedge clk);
    exp_reg(REG_STAT, IMPL, "R5 active-low lines pending with pins low");
    wr(REG_MODE, 32'h0);
    wr(REG_STAT_CLR, 32'hFFFF_FFFF);
    exp_reg(REG_STAT, 32'h0, "R4 clear after return to edge mode");

    // R2 mask set / clear
    wr(REG_EN_SET, 32'h0000_00F5);
    exp_reg(REG_MASK, 32'h0000_00F5, "R2 mask set");
    wr(REG_EN_SET, 32'hFFFF_FFFF);
    exp_reg(REG_MASK, IMPL, "R2 R7 mask set all");
    wr(REG_EN_CLR, 32'h0000_0005);
    exp_reg(REG_MASK, IMPL & ~32'h5, "R2 mask clear");
    wr(REG_EN_CLR, 32'h0);
    exp_reg(REG_MASK, IMPL & ~32'h5, "R2 zero clear no effect");
    wr(REG_EN_CLR, 32'hFFFF_FFFF);
    exp_reg(REG_MASK, 32'h0, "R2 mask clear all");

    // R3 edge polarity, R4 stickiness
    wr(REG_EDGE, 32'h0000_0002);
    set_pin(1, 1'b1);
    exp_reg(REG_STAT, 32'h2, "R3 rising edge line1");
    set_pin(1, 1'b0);
    exp_reg(REG_STAT, 32'h2, "R4 sticky after pin falls");
    set_pin(2, 1'b1);
    exp_reg(REG_STAT, 32'h2, "R3 rise ignored on falling line2");
    set_pin(2, 1'b0);
    exp_reg(REG_STAT, 32'h6, "R3 falling edge line2");

    // R8 combined request
    exp_irq(1'b0, "R8 irq low while all masked");
    wr(REG_EN_SET, 32'h4);
    exp_irq(1'b1, "R8 irq high pending and unmasked");
    wr(REG_STAT_CLR, 32'h4);
    exp_reg(REG_STAT, 32'h2, "R4 clear only line2");
    exp_irq(1'b0, "R8 irq low when unmasked line cleared");
    wr(REG_STAT_CLR, 32'h2);
    exp_reg(REG_STAT, 32'h0, "R4 clear line1");

    // R5 level sensing
    wr(REG_MODE, 32'h0000_0018);
    wr(REG_LEVEL, 32'h0000_0010);
    repeat (4) @(posedge clk);
    exp_reg(REG_STAT, 32'h8, "R5 active-low line3 pending");
    wr(REG_STAT_CLR, 32'h8);
    repeat (2) @(posedge clk);
    exp_reg(REG_STAT, 32'h8, "R5 clear has no effect on active level");
    set_pin(3, 1'b1);
    exp_reg(REG_STAT, 32'h0, "R5 level line3 drops with pin");
    set_pin(4, 1'b1);
    exp_reg(REG_STAT, 32'h10, "R5 active-high line4 pending");
    set_pin(4, 1'b0);
    exp_reg(REG_STAT, 32'h0, "R5 level line4 drops with pin");

    // R6 clear and detection in the same cycle
    wr(REG_EDGE, 32'h0000_0022);
    repeat (2) @(posedge clk);
    exp_reg(REG_STAT, 32'h0, "R6 precondition");
    @(posedge clk); #1 ext_pin[5] = 1'b1;
    @(posedge clk); #1;
    @(posedge clk); #1;
    bus_addr = 8'(REG_STAT_CLR); bus_wdata = 32'h20; bus_we = 1'b1;
    @(posedge clk); #1 bus_we = 1'b0;
    exp_reg(REG_STAT, 32'h20, "R6 detection wins over clear");
    wr(REG_STAT_CLR, 32'h20);
    exp_reg(REG_STAT, 32'h0, "R6 plain clear afterwards");

    // R9 non-maskable path
    wr(REG_NMI, 32'h1);
    exp_reg(REG_NMI, 32'h1, "R9 nmi enable readback");
    exp_nmi(1'b0, "R9 nmi low without line0 pending");
    set_pin(0, 1'b1);
    set_pin(0, 1'b0);
    exp_reg(REG_STAT, 32'h1, "R3 falling edge line0");
    exp_nmi(1'b1, "R9 nmi high while line0 masked");
    exp_irq(1'b0, "R8 irq low line0 masked");
    wr(REG_NMI, 32'h0);
    exp_nmi(1'b0, "R9 nmi low when disabled");

    // R7 R10 unimplemented bits and write-only reads
    wr(REG_EDGE, 32'hFFFF_FFFF);
    exp_reg(REG_EDGE, IMPL, "R7 edge upper bits ignored");
    wr(REG_LEVEL, 32'hFFF0_0000);
    exp_reg(REG_LEVEL, 32'h0, "R7 level upper-only write ignored");
    exp_reg(REG_EN_SET, 32'h0, "R10 set register reads 0");
    exp_reg(REG_EN_CLR, 32'h0, "R10 clear register reads 0");
    exp_reg(REG_STAT_CLR, 32'h0, "R10 pending-clear reads 0");
    exp_reg('h20, 32'h0, "R10 unassigned offset reads 0");

    @(posedge clk);
    @(negedge clk);
    done = 1;
    print_summary();
    $finish;
  end

endmodule